// File: doc/BRIEF.md
# Lockable Windowed Watchdog Timer

This block is a watchdog peripheral for a processor subsystem. A 12-bit down-counter steps once per pulse of a slow tick input, normally 256 Hz. Software must service it with a keyed restart command before the count runs out. If the count underflows, or if software restarts too early, the block takes the configured fault action. That action is a level interrupt, a one-cycle reset request, or both. Counting can pause while the processor is idle or halted by a debugger, when the matching enable bits are set.

Software reaches the block through a single-cycle register port with three word addresses:

- Word 0 is the write-only command word.
- Word 1 is the mode word.
- Word 2 is the status word.

The port has no valid/ready handshake and applies no back-pressure. Every access with `bus_sel` high completes in the cycle it is presented. Read data is combinational from the current state.

The mode word can be rewritten any number of times until a keyed lock command freezes it. After that it stays frozen until reset. To reach a timeout of S seconds with the 256 Hz tick, software loads the reload and window fields with S*256-1.

Top module: `guard_timer`

## Requirements
- R1: After reset:
  - the mode word reads 0x0FFF_2FFF, meaning reload 0xFFF in bits 11:0, window limit 0xFFF in bits 27:16, reset action enabled at bit 13, and all other bits zero;
  - the status word reads 0;
  - `fault_irq` and `reset_req` are low;
  - the lock is clear.
- R2: The mode word bit layout is:
  - reload value in bits 11:0;
  - interrupt action enable at bit 12;
  - reset action enable at bit 13;
  - disable at bit 15;
  - window limit in bits 27:16;
  - debug-pause enable at bit 28;
  - idle-pause enable at bit 29.

  While unlocked, the mode word accepts any number of writes and reads back what was written in those fields. A write whose values are accepted reloads the counter from the newly written reload value.
- R3: A command-word write with 0xA5 in bits 31:24 and bit 4 set locks the mode word. From then until reset, mode writes have no effect. The same lock bit with any other key is ignored.
- R4: While the disable bit is currently set, a mode write leaves the reload and window fields unchanged. The flag bits of that write still take effect.
- R5: While enabled and not paused, each tick pulse decrements the counter. A tick arriving with the counter at 0 is an underflow. The underflow reloads the counter and sets status bit 0. The first underflow after a reload therefore happens on tick number reload+1.
- R6: A command-word write with key 0xA5 in bits 31:24 and bit 0 set is a restart. When the counter is at or below the window limit, the restart reloads the counter from the reload value. The restart bit with a wrong key has no effect.
- R7: A keyed restart while the counter is above the window limit is a window error. It sets status bit 1, leaves the counter unchanged, and triggers the fault action.
- R8: On an underflow or window error:
  - if bit 12 is set, `fault_irq` goes high and stays high while a status flag remains set;
  - if bit 13 is set, `reset_req` pulses high for exactly one cycle after the event.
- R9: Counting pauses while `dbg_halt_i` is high with bit 28 set, or while `idle_i` is high with bit 29 set. Either halt input has no effect when its enable bit is clear.
- R10: A read of the status word returns the two flags and clears them. An event in the same cycle as the read leaves its flag set.
- R11: While disabled (bit 15 set), the counter does not run. No underflow or window error can occur, and restarts are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-enable pulse from the slow timebase, one clock wide |
| idle_i | input | 1 | Processor idle indication |
| dbg_halt_i | input | 1 | Processor debug-halt indication |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 command, 1 mode, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| fault_irq | output | 1 | Level fault interrupt |
| reset_req | output | 1 | One-cycle reset request pulse |

## Verification

The bench sweeps the reload value from 0 to 6 and checks that the underflow lands exactly on tick number reload+1. A counter that reloaded one value off, or that flagged underflow on reaching zero instead of on the following tick, would miss that tick by one.

For a reload value of 7, the bench sweeps every window limit from 0 to 7 against every early-restart point from 0 to 7. This catches an inclusive/exclusive slip in the window compare, and a restart that reloads after an error.

It also checks these cases:
- a write that keeps or clears the disable bit while disable is set, where a design that accepts the new values would read back the wrong reload field;
- halt inputs with their enable bits both set and clear;
- the lock command with a wrong key, and with the correct key;
- a restart with a wrong key, which must not rescue the counter from underflow.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int CNT_W = 12;
  localparam logic [7:0] CMD_KEY = 8'hA5;

  localparam int B_RESTART = 0;
  localparam int B_LOCK    = 4;
  localparam int B_IRQ_EN  = 12;
  localparam int B_RST_EN  = 13;
  localparam int B_DIS     = 15;
  localparam int B_DELTA   = 16;
  localparam int B_DBG     = 28;
  localparam int B_IDLE    = 29;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_MODE = 2'd1,
    A_STAT = 2'd2,
    A_NONE = 2'd3
  } addr_e;

  typedef struct packed {
    logic             idle_halt;
    logic             dbg_halt;
    logic             dis;
    logic             rst_en;
    logic             irq_en;
    logic [CNT_W-1:0] delta;
    logic [CNT_W-1:0] load;
  } mode_t;

  localparam mode_t MODE_RESET = '{
    idle_halt: 1'b0,
    dbg_halt:  1'b0,
    dis:       1'b0,
    rst_en:    1'b1,
    irq_en:    1'b0,
    delta:     {CNT_W{1'b1}},
    load:      {CNT_W{1'b1}}
  };

  function automatic logic [31:0] mode_image(input mode_t m);
    logic [31:0] w;
    w = '0;
    w[CNT_W-1:0]          = m.load;
    w[B_IRQ_EN]           = m.irq_en;
    w[B_RST_EN]           = m.rst_en;
    w[B_DIS]              = m.dis;
    w[B_DELTA +: CNT_W]   = m.delta;
    w[B_DBG]              = m.dbg_halt;
    w[B_IDLE]             = m.idle_halt;
    return w;
  endfunction
endpackage

// File: rtl/gt_regs.sv
module gt_regs
  import gt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        lock_cmd,
  input  logic [31:0] wdata,
  output mode_t       mode_q,
  output logic        lock_q,
  output logic        val_take
);
  wire unused_wdata_bits = ^{wdata[31:30], wdata[14]};

  // New reload/window values are taken only while unlocked and not disabled.
  assign val_take = wr_en && !lock_q && !mode_q.dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      lock_q <= 1'b0;
    end else begin
      if (wr_en && !lock_q) begin
        mode_q.irq_en    <= wdata[B_IRQ_EN];
        mode_q.rst_en    <= wdata[B_RST_EN];
        mode_q.dis       <= wdata[B_DIS];
        mode_q.dbg_halt  <= wdata[B_DBG];
        mode_q.idle_halt <= wdata[B_IDLE];
      end
      if (val_take) begin
        mode_q.load  <= wdata[CNT_W-1:0];
        mode_q.delta <= wdata[B_DELTA +: CNT_W];
      end
      if (lock_cmd) lock_q <= 1'b1;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R3
  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(mode_q)); // R3
  AST_DIS_KEEPS_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.dis |=> ($stable(mode_q.load) && $stable(mode_q.delta))); // R4
endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          tick,
  input  logic          paused,
  input  logic          reload,
  input  logic          restart_req,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] delta,
  output logic [CW-1:0] cnt_q,
  output logic          uf_evt,
  output logic          win_err_evt
);
  logic step, rs_ok;

  assign step        = run_en && tick && !paused;
  assign uf_evt      = step && (cnt_q == '0);
  assign rs_ok       = run_en && restart_req && (cnt_q <= delta);
  assign win_err_evt = run_en && restart_req && (cnt_q > delta);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt_q <= '1;
    else if (!run_en || reload || rs_ok)   cnt_q <= load_val;
    else if (win_err_evt)                  cnt_q <= cnt_q;
    else if (step)                         cnt_q <= (cnt_q == '0) ? load_val : cnt_q - 1'b1;
  end

  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && paused && !reload && !restart_req) |=> $stable(cnt_q)); // R9
  AST_RELOAD_AFTER_UF: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> (cnt_q == $past(load_val))); // R5
  AST_ERR_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_err_evt && !reload) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/gt_status.sv
module gt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_uf,
  input  logic set_err,
  input  logic rd_clr,
  output logic uf_q,
  output logic err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (set_uf)      uf_q <= 1'b1;
      else if (rd_clr) uf_q <= 1'b0;
      if (set_err)      err_q <= 1'b1;
      else if (rd_clr)  err_q <= 1'b0;
    end
  end

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set_uf && !set_err) |=> (!uf_q && !err_q)); // R10
  AST_UF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_uf |=> uf_q); // R5
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |=> err_q); // R7
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gt_pkg::*;
#(
  parameter logic [7:0] KEY = CMD_KEY
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        idle_i,
  input  logic        dbg_halt_i,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        fault_irq,
  output logic        reset_req
);
  mode_t            mode_q;
  logic             lock_q, val_take;
  logic             ctrl_wr, mode_wr, stat_rd, key_ok;
  logic             restart_req, lock_cmd, paused;
  logic [CNT_W-1:0] reload_val, cnt_q;
  logic             uf_evt, win_err_evt, uf_q, err_q;

  assign key_ok      = (bus_wdata[31:24] == KEY);
  assign ctrl_wr     = bus_sel && bus_we && (bus_addr == A_CTRL);
  assign mode_wr     = bus_sel && bus_we && (bus_addr == A_MODE);
  assign stat_rd     = bus_sel && !bus_we && (bus_addr == A_STAT);
  assign restart_req = ctrl_wr && key_ok && bus_wdata[B_RESTART];
  assign lock_cmd    = ctrl_wr && key_ok && bus_wdata[B_LOCK];
  assign paused      = (mode_q.dbg_halt && dbg_halt_i) || (mode_q.idle_halt && idle_i);
  assign reload_val  = val_take ? bus_wdata[CNT_W-1:0] : mode_q.load;

  gt_regs regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (mode_wr),
    .lock_cmd (lock_cmd),
    .wdata    (bus_wdata),
    .mode_q   (mode_q),
    .lock_q   (lock_q),
    .val_take (val_take)
  );

  gt_counter #(.CW(CNT_W)) cnt_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (!mode_q.dis),
    .tick        (tick_i),
    .paused      (paused),
    .reload      (val_take),
    .restart_req (restart_req),
    .load_val    (reload_val),
    .delta       (mode_q.delta),
    .cnt_q       (cnt_q),
    .uf_evt      (uf_evt),
    .win_err_evt (win_err_evt)
  );

  gt_status stat_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_uf  (uf_evt),
    .set_err (win_err_evt),
    .rd_clr  (stat_rd),
    .uf_q    (uf_q),
    .err_q   (err_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= mode_q.rst_en && (uf_evt || win_err_evt);
  end

  assign fault_irq = mode_q.irq_en && (uf_q || err_q);

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode_image(mode_q);
      A_STAT:  bus_rdata = {30'd0, err_q, uf_q};
      default: bus_rdata = '0;
    endcase
  end

  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(mode_q.rst_en)); // R8
  AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.dis && !uf_q && !err_q) |=> (!uf_q && !err_q)); // R11
endmodule

// File: tb/guard_timer_tb.sv
module guard_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, idle_i = 1'b0, dbg_halt_i = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        fault_irq, reset_req;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;
  logic last_rr = 1'b0;

  localparam logic [31:0] F_IRQ  = 32'h0000_1000;
  localparam logic [31:0] F_RST  = 32'h0000_2000;
  localparam logic [31:0] F_DIS  = 32'h0000_8000;
  localparam logic [31:0] F_DBG  = 32'h1000_0000;
  localparam logic [31:0] F_IDLE = 32'h2000_0000;
  localparam logic [31:0] C_RESTART = 32'hA500_0001;
  localparam logic [31:0] C_LOCK    = 32'hA500_0010;

  always #4 clk = ~clk;

  guard_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .idle_i(idle_i), .dbg_halt_i(dbg_halt_i),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .fault_irq(fault_irq), .reset_req(reset_req)
  );

  function automatic logic [31:0] mw(input int cnt, input int dlt, input logic [31:0] flags);
    return (32'(dlt) << 16) | 32'(cnt) | flags;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = 32'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      last_rr = reset_req;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL WATCHDOG: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd1, d); chk("R1 mode", d, 32'h0FFF_2FFF);
    rd(2'd2, d); chk("R1 status", d, 32'd0);
    chk("R1 irq", {31'd0, fault_irq}, 32'd0);
    chk("R1 rst", {31'd0, reset_req}, 32'd0);

    // R2 repeated writes while unlocked
    wr(2'd1, mw(3, 3, F_RST));        rd(2'd1, d); chk("R2 first", d, mw(3, 3, F_RST));
    wr(2'd1, mw(5, 9, F_RST | F_IRQ)); rd(2'd1, d); chk("R2 second", d, mw(5, 9, F_RST | F_IRQ));

    // R5 / R8 / R10 underflow timing sweep
    for (int n = 0; n <= 6; n++) begin
      wr(2'd1, mw(n, n, F_RST | F_IRQ));
      rd(2'd2, d);
      ticks(n);
      rd(2'd2, d); chk($sformatf("R5 no uf before tick %0d", n + 1), d, 32'd0);
      ticks(1);
      chk("R8 reset pulse", {31'd0, last_rr}, 32'd1);
      chk("R8 reset one cycle", {31'd0, reset_req}, 32'd0);
      chk("R8 irq level", {31'd0, fault_irq}, 32'd1);
      rd(2'd2, d); chk($sformatf("R5 uf at tick %0d", n + 1), d, 32'd1);
      rd(2'd2, d); chk("R10 cleared by read", d, 32'd0);
    end

    // R6 / R7 window sweep, reload 7
    for (int dl = 0; dl <= 7; dl++) begin
      for (int k = 0; k <= 7; k++) begin
        bit err;
        err = ((7 - k) > dl);
        wr(2'd1, mw(7, dl, F_RST));
        rd(2'd2, d);
        ticks(k);
        wr(2'd0, C_RESTART);
        rd(2'd2, d);
        chk($sformatf("%s d=%0d k=%0d", err ? "R7 window error" : "R6 window ok", dl, k),
            d, err ? 32'd2 : 32'd0);
        if (!err) begin
          ticks(7);
          rd(2'd2, d); chk("R6 restart reloads", d, 32'd0);
        end else begin
          ticks(8 - k);
          rd(2'd2, d); chk("R7 count kept after error", d, 32'd1);
        end
      end
    end

    // R6 wrong key does not restart
    wr(2'd1, mw(2, 2, F_RST));
    rd(2'd2, d);
    ticks(2);
    wr(2'd0, 32'h5A00_0001);
    ticks(1);
    rd(2'd2, d); chk("R6 bad key ignored", d, 32'd1);

    // R9 pause inputs
    wr(2'd1, mw(2, 2, F_RST | F_DBG | F_IDLE));
    rd(2'd2, d);
    dbg_halt_i = 1'b1; ticks(5);
    rd(2'd2, d); chk("R9 debug pause", d, 32'd0);
    dbg_halt_i = 1'b0; idle_i = 1'b1; ticks(5);
    rd(2'd2, d); chk("R9 idle pause", d, 32'd0);
    idle_i = 1'b0; ticks(2);
    rd(2'd2, d); chk("R9 resume no uf", d, 32'd0);
    ticks(1);
    rd(2'd2, d); chk("R9 resume uf", d, 32'd1);
    wr(2'd1, mw(2, 2, F_RST));
    dbg_halt_i = 1'b1; idle_i = 1'b1;
    ticks(3);
    dbg_halt_i = 1'b0; idle_i = 1'b0;
    rd(2'd2, d); chk("R9 halts ignored when not enabled", d, 32'd1);

    // R11 / R4 disable
    wr(2'd1, mw(2, 2, F_RST | F_DIS));
    rd(2'd2, d);
    ticks(5);
    chk("R11 no reset pulse", {31'd0, last_rr}, 32'd0);
    wr(2'd0, C_RESTART);
    rd(2'd2, d); chk("R11 disabled silent", d, 32'd0);
    wr(2'd1, mw(9, 9, F_RST | F_DIS));
    rd(2'd1, d); chk("R4 keep-disable write", d, mw(2, 2, F_RST | F_DIS));
    wr(2'd1, mw(9, 9, F_RST));
    rd(2'd1, d); chk("R4 re-enable write", d, mw(2, 2, F_RST));
    wr(2'd1, mw(4, 4, F_RST));
    rd(2'd1, d); chk("R4 enabled write", d, mw(4, 4, F_RST));

    // R3 lock
    wr(2'd0, 32'h5A00_0010);
    wr(2'd1, mw(6, 6, F_RST));
    rd(2'd1, d); chk("R3 bad key no lock", d, mw(6, 6, F_RST));
    wr(2'd0, C_LOCK);
    wr(2'd1, mw(1, 1, F_DIS));
    rd(2'd1, d); chk("R3 locked", d, mw(6, 6, F_RST));
    rd(2'd2, d);
    ticks(6);
    rd(2'd2, d); chk("R3 counts with kept value", d, 32'd0);
    ticks(1);
    rd(2'd2, d); chk("R3 uf with kept value", d, 32'd1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule